// File: doc/BRIEF.md
# 8x8 Tile DCT Encoder

The block compresses a grayscale frame held in an external pixel memory one 8x8 tile at a time. For each tile it fetches the 64 unsigned 8-bit pixels, runs a two-dimensional discrete cosine transform as two matrix products (Y = C·X·Cᵀ) with a signed fixed-point cosine table, and keeps only the ten lowest-frequency results. Those ten values are clipped to narrow signed fields and packed into one 78-bit word, which is written to an output buffer at the tile's index. With the default 240x240 frame there are 30x30 = 900 tiles, so a frame becomes 70,200 bits.

Software or a host sequencer pulses `start`. The block then walks every tile in raster order (left to right, then top to bottom), holding `busy` high, and raises `done` for one cycle once the last word has been written. The pixel memory is read through a simple port with one cycle of read latency. Inside, a control state machine steps through loading, a row pass with eight parallel multipliers into a transposition buffer, a column pass that evaluates only the kept coefficients, a packing step and a write step.

Top module: `dct_tile_encoder`

## Requirements
- R1: After reset `busy`, `done`, `pix_rd_en` and `enc_wr_en` are all low, and they stay low until `start` is seen.
- R2: A `start` high on a clock edge while idle begins a frame; `start` while `busy` is ignored, so the frame still yields exactly one write per tile and a single `done`.
- R3: Tile t (column tx = t mod TILES_X, row ty = t div TILES_X) is fetched with 64 reads in row-major order: read i addresses (8·ty + i div 8)·IMG_W + 8·tx + (i mod 8); the pixel is on `pix_rd_data` the cycle after the read.
- R4: Tiles are encoded in raster order; the word of tile t is written with `enc_wr_addr` = t, once per tile, in ascending order.
- R5: The cosine table C[k][n] (k frequency, n sample) is signed Q1.7: 45 for k = 0, otherwise round(64·cos((2n+1)kπ/16)), i.e. magnitudes 64, 63, 59, 53, 45, 36, 24, 12, 0 for angle multiples 0..8 of π/16, with the sign of the cosine.
- R6: The row pass forms T[r][v] = floor((Σc X[r][c]·C[v][c]) / 128) with X the unsigned pixel at tile row r, column c.
- R7: The column pass forms Y[u][v] = floor((Σr C[u][r]·T[r][v]) / 128); a tile of all 255 gives Y[0][0] = 2016.
- R8: The kept coefficients are, in zigzag order, (u,v) = (0,0),(0,1),(1,0),(2,0),(1,1),(0,2),(0,3),(1,2),(2,1),(3,0); the DC term occupies bits [14:0] and the k-th kept AC term (k = 1..9) bits [15+7(k−1) +: 7], all two's complement. An all-zero tile gives an all-zero word.
- R9: Each kept value is saturated to its field: DC to −16384..16383, AC to −64..63 (a left-bright/right-dark half tile gives +63 in field 1, the mirror gives −64).
- R10: `done` is a one-cycle pulse in the cycle after the last tile's write, with `busy` low from that cycle on; `busy` is high from the cycle after `start` is accepted until then, and no reads or writes occur while idle.
- R11: Each tile issues exactly 64 pixel reads before its single write, and no read happens in a write cycle.
- R12: Consecutive tile writes within a frame are exactly 141 cycles apart (65 load, 64 row, 10 column, 1 pack, 1 write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| start | input | 1 | Begin encoding a frame (accepted only when idle) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last tile is written |
| pix_rd_en | output | 1 | Pixel memory read strobe |
| pix_rd_addr | output | ADDR_W (16) | Pixel address, row-major over the frame |
| pix_rd_data | input | PIX_W (8) | Pixel returned one cycle after the read |
| enc_wr_en | output | 1 | Encoded word write strobe |
| enc_wr_addr | output | TIDX_W (10) | Tile index of the word being written |
| enc_wr_data | output | PACK_W (78) | Packed coefficients of the tile |

## Verification
The bound checker watches the handshake and memory-port discipline on every cycle: the single-cycle write and done strobes, done arriving only right after a write and with the block idle, addresses in range, no read in a write cycle, and exactly 64 reads between tile writes. The arithmetic itself (table values, floor truncation of both passes, zigzag selection, field layout and saturation), raster ordering of read addresses, the ignored mid-frame start and the 141-cycle tile cadence are only visible from the bench's scenarios, which compare each written word against a model built from cosine values computed in floating point.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int TILE      = 8;
  localparam int TILE_PIX  = TILE * TILE;
  localparam int COEF_W    = 8;   // signed Q1.7
  localparam int COEF_FRAC = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ROW,
    ST_COL,
    ST_PACK,
    ST_WRITE
  } enc_state_e;

  // Cosine basis entry for frequency k and sample n, scaled by 128.
  function automatic logic signed [COEF_W-1:0] dct_coef(input int k, input int n);
    int   ang;
    int   mag;
    logic neg;
    if (k == 0) return COEF_W'(45);
    ang = ((2 * n + 1) * k) % 32;
    neg = 1'b0;
    if (ang > 16) ang = 32 - ang;
    if (ang > 8) begin
      neg = 1'b1;
      ang = 16 - ang;
    end
    case (ang)
      0: mag = 64;
      1: mag = 63;
      2: mag = 59;
      3: mag = 53;
      4: mag = 45;
      5: mag = 36;
      6: mag = 24;
      7: mag = 12;
      default: mag = 0;
    endcase
    return neg ? COEF_W'(-mag) : COEF_W'(mag);
  endfunction

  // Zigzag scan position k -> {u, v} packed as u*8+v.
  function automatic logic [5:0] zz_pos(input logic [3:0] k);
    case (k)
      4'd0:  return 6'd0;
      4'd1:  return 6'd1;
      4'd2:  return 6'd8;
      4'd3:  return 6'd16;
      4'd4:  return 6'd9;
      4'd5:  return 6'd2;
      4'd6:  return 6'd3;
      4'd7:  return 6'd10;
      4'd8:  return 6'd17;
      4'd9:  return 6'd24;
      4'd10: return 6'd32;
      4'd11: return 6'd25;
      4'd12: return 6'd18;
      4'd13: return 6'd11;
      4'd14: return 6'd4;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int TILES_X = 30,
  parameter int TILES_Y = 30,
  parameter int KEEP    = 10,
  localparam int NTILES = TILES_X * TILES_Y,
  localparam int TX_W   = (TILES_X > 1) ? $clog2(TILES_X) : 1,
  localparam int TY_W   = (TILES_Y > 1) ? $clog2(TILES_Y) : 1,
  localparam int TIDX_W = (NTILES > 1) ? $clog2(NTILES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output enc_state_e        state_o,
  output logic [6:0]        step_o,
  output logic [TX_W-1:0]   tile_x_o,
  output logic [TY_W-1:0]   tile_y_o,
  output logic [TIDX_W-1:0] tile_idx_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int LOAD_LAST = TILE_PIX;      // one extra cycle for read latency
  localparam int ROW_LAST  = TILE_PIX - 1;
  localparam int COL_LAST  = KEEP - 1;

  enc_state_e        state_q, state_d;
  logic [6:0]        step_q, step_d;
  logic              step_en;
  logic [TX_W-1:0]   tx_q;
  logic [TY_W-1:0]   ty_q;
  logic [TIDX_W-1:0] tidx_q;
  logic              done_q;
  logic              last_tile;
  logic              accept;
  logic              advance;

  assign last_tile = (tidx_q == TIDX_W'(NTILES - 1));
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign advance   = (state_q == ST_WRITE) && !last_tile;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD:  if (step_q == 7'(LOAD_LAST)) state_d = ST_ROW;
      ST_ROW:   if (step_q == 7'(ROW_LAST)) state_d = ST_COL;
      ST_COL:   if (step_q == 7'(COL_LAST)) state_d = ST_PACK;
      ST_PACK:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_tile ? ST_IDLE : ST_LOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_en = (state_q != ST_IDLE) || (state_d != ST_IDLE);
    step_d  = (state_d != state_q) ? 7'd0 : step_q + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      tx_q    <= '0;
      ty_q    <= '0;
      tidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
      if (accept) begin
        tx_q   <= '0;
        ty_q   <= '0;
        tidx_q <= '0;
      end else if (advance) begin
        tidx_q <= tidx_q + TIDX_W'(1);
        if (tx_q == TX_W'(TILES_X - 1)) begin
          tx_q <= '0;
          ty_q <= ty_q + TY_W'(1);
        end else begin
          tx_q <= tx_q + TX_W'(1);
        end
      end
      done_q <= (state_q == ST_WRITE) && last_tile;
    end
  end

  assign state_o    = state_q;
  assign step_o     = step_q;
  assign tile_x_o   = tx_q;
  assign tile_y_o   = ty_q;
  assign tile_idx_o = tidx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/dct_row_stage.sv
module dct_row_stage
  import dct_pkg::*;
#(
  parameter int PIX_W  = 8,
  localparam int PROD_W = PIX_W + 1 + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TILE),
  localparam int T_W    = ACC_W - COEF_FRAC
) (
  input  logic                  clk,
  input  logic                  ld_en_i,
  input  logic [5:0]            ld_idx_i,
  input  logic [PIX_W-1:0]      ld_pix_i,
  input  logic                  row_en_i,
  input  logic [5:0]            row_idx_i,
  output logic                  t_we_o,
  output logic [5:0]            t_idx_o,
  output logic signed [T_W-1:0] t_val_o
);

  logic [PIX_W-1:0]         xbuf [TILE_PIX];
  logic signed [COEF_W-1:0] ctab [TILE][TILE];
  logic signed [PROD_W-1:0] prod [TILE];
  logic signed [ACC_W-1:0]  acc;
  logic [2:0]               row_r;
  logic [2:0]               freq_v;

  for (genvar k = 0; k < TILE; k++) begin : g_ck
    for (genvar n = 0; n < TILE; n++) begin : g_cn
      assign ctab[k][n] = dct_coef(k, n);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en_i) xbuf[ld_idx_i] <= ld_pix_i;
  end

  assign row_r  = row_idx_i[5:3];
  assign freq_v = row_idx_i[2:0];

  // Eight parallel products: one row of pixels against one basis row.
  for (genvar c = 0; c < TILE; c++) begin : g_mul
    assign prod[c] = $signed({1'b0, xbuf[{row_r, 3'(c)}]}) * ctab[freq_v][c];
  end

  always_comb begin
    acc = '0;
    for (int c = 0; c < TILE; c++) begin
      acc = acc + ACC_W'(prod[c]);
    end
  end

  assign t_we_o  = row_en_i;
  assign t_idx_o = row_idx_i;
  assign t_val_o = T_W'(acc >>> COEF_FRAC);

endmodule

// File: rtl/dct_col_stage.sv
module dct_col_stage
  import dct_pkg::*;
#(
  parameter int T_W  = 13,
  parameter int DC_W = 15,
  parameter int AC_W = 7,
  parameter int KEEP = 10,
  localparam int K_W    = $clog2(KEEP),
  localparam int PACK_W = DC_W + (KEEP - 1) * AC_W,
  localparam int PROD_W = T_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TILE),
  localparam int Y_W    = ACC_W - COEF_FRAC
) (
  input  logic                  clk,
  input  logic                  t_we_i,
  input  logic [5:0]            t_idx_i,
  input  logic signed [T_W-1:0] t_val_i,
  input  logic                  col_en_i,
  input  logic [K_W-1:0]        col_k_i,
  output logic [PACK_W-1:0]     pack_o
);

  localparam logic signed [Y_W-1:0] DC_HI = Y_W'((2 ** (DC_W - 1)) - 1);
  localparam logic signed [Y_W-1:0] DC_LO = -DC_HI - Y_W'(1);
  localparam logic signed [Y_W-1:0] AC_HI = Y_W'((2 ** (AC_W - 1)) - 1);
  localparam logic signed [Y_W-1:0] AC_LO = -AC_HI - Y_W'(1);

  logic signed [T_W-1:0]    tbuf [TILE_PIX];
  logic signed [COEF_W-1:0] ctab [TILE][TILE];
  logic signed [PROD_W-1:0] prod [TILE];
  logic signed [ACC_W-1:0]  acc;
  logic signed [Y_W-1:0]    y;
  logic [5:0]               pos;
  logic [2:0]               fu;
  logic [2:0]               fv;
  logic [DC_W-1:0]          dc_sat;
  logic [AC_W-1:0]          ac_sat;
  logic [DC_W-1:0]          dc_q;
  logic [AC_W-1:0]          ac_q [KEEP-1];

  for (genvar k = 0; k < TILE; k++) begin : g_ck
    for (genvar n = 0; n < TILE; n++) begin : g_cn
      assign ctab[k][n] = dct_coef(k, n);
    end
  end

  // Transposition buffer written by the row pass.
  always_ff @(posedge clk) begin
    if (t_we_i) tbuf[t_idx_i] <= t_val_i;
  end

  assign pos = zz_pos(4'(col_k_i));
  assign fu  = pos[5:3];
  assign fv  = pos[2:0];

  for (genvar r = 0; r < TILE; r++) begin : g_mul
    assign prod[r] = ctab[fu][r] * tbuf[{3'(r), fv}];
  end

  always_comb begin
    acc = '0;
    for (int r = 0; r < TILE; r++) begin
      acc = acc + ACC_W'(prod[r]);
    end
    y = Y_W'(acc >>> COEF_FRAC);
  end

  always_comb begin
    if (y > DC_HI)      dc_sat = DC_HI[DC_W-1:0];
    else if (y < DC_LO) dc_sat = DC_LO[DC_W-1:0];
    else                dc_sat = y[DC_W-1:0];
    if (y > AC_HI)      ac_sat = AC_HI[AC_W-1:0];
    else if (y < AC_LO) ac_sat = AC_LO[AC_W-1:0];
    else                ac_sat = y[AC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (col_en_i && (col_k_i == '0)) dc_q <= dc_sat;
  end

  for (genvar f = 1; f < KEEP; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (col_en_i && (col_k_i == K_W'(f))) ac_q[f-1] <= ac_sat;
    end
    assign pack_o[DC_W + AC_W * (f - 1) +: AC_W] = ac_q[f-1];
  end

  assign pack_o[DC_W-1:0] = dc_q;

endmodule

// File: rtl/dct_tile_encoder.sv
module dct_tile_encoder
  import dct_pkg::*;
#(
  parameter int IMG_W = 240,
  parameter int IMG_H = 240,
  parameter int PIX_W = 8,
  parameter int DC_W  = 15,
  parameter int AC_W  = 7,
  parameter int KEEP  = 10,
  localparam int TILES_X = IMG_W / TILE,
  localparam int TILES_Y = IMG_H / TILE,
  localparam int NTILES  = TILES_X * TILES_Y,
  localparam int ADDR_W  = $clog2(IMG_W * IMG_H),
  localparam int TIDX_W  = (NTILES > 1) ? $clog2(NTILES) : 1,
  localparam int PACK_W  = DC_W + (KEEP - 1) * AC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pix_rd_en,
  output logic [ADDR_W-1:0] pix_rd_addr,
  input  logic [PIX_W-1:0]  pix_rd_data,
  output logic              enc_wr_en,
  output logic [TIDX_W-1:0] enc_wr_addr,
  output logic [PACK_W-1:0] enc_wr_data
);

  localparam int TX_W  = (TILES_X > 1) ? $clog2(TILES_X) : 1;
  localparam int TY_W  = (TILES_Y > 1) ? $clog2(TILES_Y) : 1;
  localparam int K_W   = $clog2(KEEP);
  localparam int T_W   = PIX_W + 1 + COEF_W + $clog2(TILE) - COEF_FRAC;

  enc_state_e         state;
  logic [6:0]         step;
  logic [TX_W-1:0]    tile_x;
  logic [TY_W-1:0]    tile_y;
  logic [TIDX_W-1:0]  tile_idx;
  logic               ld_vld_q;
  logic [5:0]         ld_idx_q;
  logic               t_we;
  logic [5:0]         t_idx;
  logic signed [T_W-1:0] t_val;
  logic [PACK_W-1:0]  pack_word;
  logic [PACK_W-1:0]  enc_q;

  dct_ctrl #(
    .TILES_X (TILES_X),
    .TILES_Y (TILES_Y),
    .KEEP    (KEEP)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .state_o    (state),
    .step_o     (step),
    .tile_x_o   (tile_x),
    .tile_y_o   (tile_y),
    .tile_idx_o (tile_idx),
    .busy_o     (busy),
    .done_o     (done)
  );

  // Pixel fetch: row-major within the tile, one read per cycle.
  assign pix_rd_en   = (state == ST_LOAD) && !step[6];
  assign pix_rd_addr = ADDR_W'((int'(tile_y) * TILE + int'(step[5:3])) * IMG_W
                               + int'(tile_x) * TILE + int'(step[2:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_vld_q <= 1'b0;
      ld_idx_q <= '0;
    end else begin
      ld_vld_q <= pix_rd_en;
      if (pix_rd_en) ld_idx_q <= step[5:0];
    end
  end

  dct_row_stage #(
    .PIX_W (PIX_W)
  ) u_row (
    .clk       (clk),
    .ld_en_i   (ld_vld_q),
    .ld_idx_i  (ld_idx_q),
    .ld_pix_i  (pix_rd_data),
    .row_en_i  (state == ST_ROW),
    .row_idx_i (step[5:0]),
    .t_we_o    (t_we),
    .t_idx_o   (t_idx),
    .t_val_o   (t_val)
  );

  dct_col_stage #(
    .T_W  (T_W),
    .DC_W (DC_W),
    .AC_W (AC_W),
    .KEEP (KEEP)
  ) u_col (
    .clk      (clk),
    .t_we_i   (t_we),
    .t_idx_i  (t_idx),
    .t_val_i  (t_val),
    .col_en_i (state == ST_COL),
    .col_k_i  (step[K_W-1:0]),
    .pack_o   (pack_word)
  );

  always_ff @(posedge clk) begin
    if (state == ST_PACK) enc_q <= pack_word;
  end

  assign enc_wr_en   = (state == ST_WRITE);
  assign enc_wr_addr = tile_idx;
  assign enc_wr_data = enc_q;

endmodule

// File: rtl/dct_tile_encoder_chk.sv
module dct_tile_encoder_chk #(
  parameter int IMG_W  = 240,
  parameter int IMG_H  = 240,
  parameter int ADDR_W = 16,
  parameter int TIDX_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pix_rd_en,
  input logic [ADDR_W-1:0] pix_rd_addr,
  input logic              enc_wr_en,
  input logic [TIDX_W-1:0] enc_wr_addr
);

  localparam int NPIX   = IMG_W * IMG_H;
  localparam int NTILES = (IMG_W / 8) * (IMG_H / 8);

  logic [7:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_cnt <= '0;
    else if (enc_wr_en) rd_cnt <= '0;
    else if (pix_rd_en) rd_cnt <= rd_cnt + 8'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !pix_rd_en && !enc_wr_en));

  a_r3_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd_en |-> (int'(pix_rd_addr) < NPIX));

  a_r4_tile_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    enc_wr_en |-> (int'(enc_wr_addr) < NTILES));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(enc_wr_en) && !busy));

  a_r10_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd_en || enc_wr_en) |-> busy);

  a_r11_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    enc_wr_en |=> !enc_wr_en);

  a_r11_no_read_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_rd_en && enc_wr_en));

  a_r11_reads_per_tile: assert property (@(posedge clk) disable iff (!rst_n)
    enc_wr_en |-> (rd_cnt == 8'd64));

endmodule

bind dct_tile_encoder dct_tile_encoder_chk #(
  .IMG_W  (IMG_W),
  .IMG_H  (IMG_H),
  .ADDR_W (ADDR_W),
  .TIDX_W (TIDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .pix_rd_en   (pix_rd_en),
  .pix_rd_addr (pix_rd_addr),
  .enc_wr_en   (enc_wr_en),
  .enc_wr_addr (enc_wr_addr)
);

// File: tb/dct_tile_encoder_bench.sv
module dct_tile_encoder_bench;

  localparam int IMG_W  = 24;
  localparam int IMG_H  = 16;
  localparam int TX     = IMG_W / 8;
  localparam int NT     = TX * (IMG_H / 8);
  localparam int NPIX   = IMG_W * IMG_H;
  localparam int ADDR_W = $clog2(NPIX);
  localparam int TIDX_W = $clog2(NT);
  localparam int PACK_W = 78;
  localparam int TILE_CYC = 141;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              busy, done;
  logic              pix_rd_en;
  logic [ADDR_W-1:0] pix_rd_addr;
  logic [7:0]        pix_rd_data;
  logic              enc_wr_en;
  logic [TIDX_W-1:0] enc_wr_addr;
  logic [PACK_W-1:0] enc_wr_data;

  always #2 clk = ~clk;

  dct_tile_encoder #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_dct_tile_encoder (
    .clk, .rst_n, .start, .busy, .done,
    .pix_rd_en, .pix_rd_addr, .pix_rd_data,
    .enc_wr_en, .enc_wr_addr, .enc_wr_data
  );

  logic [7:0] mem [NPIX];

  always_ff @(posedge clk) begin
    if (pix_rd_en) pix_rd_data <= mem[pix_rd_addr];
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rd_k = 0;
  int wr_k = 0;
  int last_wr = 0;
  int done_cnt = 0;
  logic [PACK_W-1:0] got [NT];

  task automatic chk(input bit ok, input string tag,
                     input logic [PACK_W-1:0] act, input logic [PACK_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Basis from floating point cosines (R5).
  function automatic int cval(int k, int n);
    real x;
    x = (k == 0) ? 128.0 / $sqrt(8.0)
                 : 64.0 * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic logic [PACK_W-1:0] model(int t);
    int zu [10] = '{0, 0, 1, 2, 1, 0, 0, 1, 2, 3};
    int zv [10] = '{0, 1, 0, 0, 1, 2, 3, 2, 1, 0};
    int tm [8][8];
    int x, y, s, bx, by;
    logic [PACK_W-1:0] w;
    bx = (t % TX) * 8;
    by = (t / TX) * 8;
    for (int r = 0; r < 8; r++)
      for (int v = 0; v < 8; v++) begin
        s = 0;
        for (int c = 0; c < 8; c++) begin
          x = int'(mem[(by + r) * IMG_W + bx + c]);
          s += x * cval(v, c);
        end
        tm[r][v] = s >>> 7;                     // R6 floor
      end
    w = '0;
    for (int k = 0; k < 10; k++) begin
      s = 0;
      for (int r = 0; r < 8; r++) s += cval(zu[k], r) * tm[r][zv[k]];
      y = s >>> 7;                              // R7 floor
      if (k == 0) begin
        if (y > 16383) y = 16383;
        if (y < -16384) y = -16384;
        w[14:0] = 15'(y);
      end else begin
        if (y > 63) y = 63;
        if (y < -64) y = -64;
        w[15 + 7 * (k - 1) +: 7] = 7'(y);       // R8/R9 layout
      end
    end
    return w;
  endfunction

  always @(negedge clk) begin
    int t, i, ea;
    cyc++;
    if (pix_rd_en) begin
      t  = rd_k / 64;
      i  = rd_k % 64;
      ea = ((t / TX) * 8 + i / 8) * IMG_W + (t % TX) * 8 + i % 8;
      chk(int'(pix_rd_addr) == ea, "R3 read address", PACK_W'(pix_rd_addr), PACK_W'(ea));
      rd_k++;
    end
    if (enc_wr_en) begin
      chk(int'(enc_wr_addr) == wr_k, "R4 write tile index", PACK_W'(enc_wr_addr), PACK_W'(wr_k));
      chk(rd_k == (wr_k + 1) * 64, "R11 reads before write", PACK_W'(rd_k), PACK_W'((wr_k + 1) * 64));
      if (wr_k < NT) begin
        chk(enc_wr_data == model(wr_k), "R6/R7/R8 packed word", enc_wr_data, model(wr_k));
        got[wr_k] = enc_wr_data;
      end
      if (wr_k > 0)
        chk(cyc - last_wr == TILE_CYC, "R12 tile cadence", PACK_W'(cyc - last_wr), PACK_W'(TILE_CYC));
      last_wr = cyc;
      wr_k++;
    end
    if (done) done_cnt++;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(done_cnt == 1, "R10 one done pulse", PACK_W'(done_cnt), PACK_W'(1));
  endtask

  task automatic run_frame(input bit extra_start);
    rd_k = 0;
    wr_k = 0;
    done_cnt = 0;
    pulse_start();
    chk(busy == 1'b1, "R10 busy after start", PACK_W'(busy), PACK_W'(1));
    if (extra_start) begin
      repeat (300) @(negedge clk);
      pulse_start();                            // R2: ignored while busy
    end
    wait_done();
    chk(wr_k == NT, "R2/R4 writes per frame", PACK_W'(wr_k), PACK_W'(NT));
    chk(busy == 1'b0, "R10 idle after done", PACK_W'(busy), PACK_W'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pix_rd_en && !enc_wr_en, "R1 reset state",
        PACK_W'({busy, done, pix_rd_en, enc_wr_en}), PACK_W'(0));

    // Frame 1: directed tiles then random ones.
    for (int a = 0; a < NPIX; a++) begin
      int t, c;
      t = ((a / IMG_W) / 8) * TX + (a % IMG_W) / 8;
      c = (a % IMG_W) % 8;
      case (t)
        0: mem[a] = 8'd255;
        1: mem[a] = (c < 4) ? 8'd255 : 8'd0;
        2: mem[a] = (c < 4) ? 8'd0 : 8'd255;
        3: mem[a] = 8'd0;
        default: mem[a] = 8'($urandom);
      endcase
    end
    run_frame(1'b1);
    chk(got[0][14:0] == 15'd2016, "R7 flat tile DC", PACK_W'(got[0][14:0]), PACK_W'(2016));
    chk(got[1][21:15] == 7'd63, "R9 positive AC clip", PACK_W'(got[1][21:15]), PACK_W'(63));
    chk(got[2][21:15] == 7'h40, "R9 negative AC clip", PACK_W'(got[2][21:15]), PACK_W'(7'h40));
    chk(got[3] == '0, "R8 zero tile word", got[3], '0);

    // R10: nothing moves once idle.
    repeat (50) @(negedge clk);
    chk(wr_k == NT && done_cnt == 1, "R10 quiet while idle", PACK_W'(wr_k), PACK_W'(NT));

    // Frame 2: uniform random pixels.
    for (int a = 0; a < NPIX; a++) mem[a] = 8'($urandom);
    run_frame(1'b0);

    // Frame 3: black/white noise, heavy AC clipping both ways.
    for (int a = 0; a < NPIX; a++) mem[a] = ($urandom % 2 == 0) ? 8'd0 : 8'd255;
    run_frame(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule